// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the sequence of word addresses that a burst read walks through. A host loads a start address. Each step strobe then moves the address by one word. The pattern of that movement is set by a 3-bit burst-length code and a wrap-enable bit, both sampled at the moment of the load.

In continuous mode the address simply counts up. After the highest address, which is all ones, it rolls over to zero. The three linear modes cover 8, 16 and 32 words. When wrap is enabled, a linear mode confines the address to the aligned block that holds the start address: it counts up to the block's last word, returns to the block's first word, and continues back up through the start word. When wrap is disabled, a linear mode counts straight on across block edges, exactly as in continuous mode.

The address width is a parameter and must be at least 5 bits. Array access, wait-state timing and the writing of configuration are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is zero and the captured mode is continuous with wrap enabled. Steps with no prior load count 0, 1, 2 and onward.
- R2: The length code is decoded as follows. 3'b000 selects continuous. 3'b010 selects 8 words, 3'b011 selects 16 words and 3'b100 selects 32 words.
- R3: In continuous mode, each step adds one. The all-ones address steps to zero.
- R4: In a linear mode with wrap set to 1, a step changes only the low log2(length) bits, modulo the length. For example, 8-word mode starting at 0x015 gives 0x016, 0x017, 0x010, 0x011 and so on.
- R5: In a linear mode with wrap set to 0, each step adds one across block edges. For example, 8-word mode starting at 0x01E gives 0x01F, then 0x020.
- R6: The reserved codes 001, 101, 110 and 111 behave as continuous mode, whatever the value of the wrap bit.
- R7: A load takes priority over a step in the same cycle. `addr_o` equals the loaded start address in the cycle after the load.
- R8: In a cycle with neither load nor step, `addr_o` keeps its value.
- R9: The length code and the wrap bit take effect only on a load. Changing them during a burst does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset. Its release must already be synchronised to `clk` |
| load_i | input | 1 | Load the start address and capture the mode |
| start_addr_i | input | ADDR_W | Start word address |
| step_i | input | 1 | Advance the address by one word |
| blen_code_i | input | 3 | Burst-length code, sampled on load |
| wrap_en_i | input | 1 | 1 = wrap inside the aligned block, sampled on load |
| addr_o | output | ADDR_W | Current word address (registered) |

## Verification
Every result of this block appears exactly one clock after the strobe that causes it. A load presents the start address one clock later. A step presents the next address one clock later. A new mode governs the first step taken after the load cycle. The bench drives its inputs on the falling edge and advances a behavioural model on the same rising edge the design uses. It then compares `addr_o` 1 ns after that edge, on every cycle, including idle cycles and cycles in which the mode inputs are changed without a load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned LG_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    BL_CONT = 3'b000,
    BL_W8   = 3'b010,
    BL_W16  = 3'b011,
    BL_W32  = 3'b100
  } blen_e;

  // log2 of the block length; 0 means continuous (also for reserved codes)
  function automatic logic [LG_W-1:0] blen_log2(input logic [CODE_W-1:0] code);
    logic [LG_W-1:0] lg;
    case (code)
      BL_W8:   lg = 3'd3;
      BL_W16:  lg = 3'd4;
      BL_W32:  lg = 3'd5;
      default: lg = 3'd0;
    endcase
    return lg;
  endfunction
endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] mask_o
);
  logic [LG_W-1:0] lg_q, lg_d;
  logic            wrap_q, wrap_d;
  logic            full_count;

  always_comb begin
    lg_d   = lg_q;
    wrap_d = wrap_q;
    if (cap_en) begin
      lg_d   = blen_log2(code_i);
      wrap_d = wrap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_q   <= '0;
      wrap_q <= 1'b1;
    end else begin
      lg_q   <= lg_d;
      wrap_q <= wrap_d;
    end
  end

  assign full_count = !wrap_q || (lg_q == '0);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign mask_o[i] = full_count || (int'(lg_q) > i);
  end

  // R9: the mode changes only through a capture
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(mask_o));
endmodule

// File: rtl/bseq_step.sv
module bseq_step #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] incr;

  always_comb begin
    incr   = addr_i + ADDR_W'(1);
    next_o = (addr_i & ~mask_i) | (incr & mask_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] blen_code_i,
  input  logic              wrap_en_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, step_addr, mask;

  bseq_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (load_i),
    .code_i (blen_code_i),
    .wrap_i (wrap_en_i),
    .mask_o (mask)
  );

  bseq_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .mask_i (mask),
    .next_o (step_addr)
  );

  always_comb begin
    addr_d = addr_q;
    if (load_i)      addr_d = start_addr_i;
    else if (step_i) addr_d = step_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R7: load wins and shows the start address one cycle later
  a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(start_addr_i));
  // R8: idle cycles hold the address
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(addr_o));
  // R4: a step never touches bits above the wrap window
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ((addr_o ^ $past(addr_o)) & ~$past(mask)) == '0);
  // R3: with a full-width window a step is a plain increment
  a_r3_plain_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (&mask)) |=> addr_o == $past(addr_o) + ADDR_W'(1));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int unsigned AW   = 10;
  localparam int unsigned SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load, step, wrap;
  logic [AW-1:0] start;
  logic [2:0]    code;
  logic [AW-1:0] addr;

  int unsigned total = 0, bad = 0;
  int unsigned ref_addr, ref_len;
  bit          ref_wrap;
  bit          done = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load), .start_addr_i(start),
    .step_i(step), .blen_code_i(code), .wrap_en_i(wrap), .addr_o(addr)
  );

  function automatic int unsigned len_of(input logic [2:0] c);
    case (c)
      3'b010:  return 8;
      3'b011:  return 16;
      3'b100:  return 32;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int unsigned exp);
    total++;
    if (addr !== AW'(exp)) begin
      bad++;
      $display("FAIL %s: addr=0x%0h expected=0x%0h", tag, addr, exp);
    end
  endtask

  task automatic tick(input bit l, input bit s, input int unsigned a,
                      input logic [2:0] c, input bit w, input string tag);
    @(negedge clk);
    load = l; step = s; start = AW'(a); code = c; wrap = w;
    @(posedge clk);
    if (l) begin
      ref_addr = a; ref_len = len_of(c); ref_wrap = w;
    end else if (s) begin
      if (ref_wrap && ref_len != 0)
        ref_addr = (ref_addr - ref_addr % ref_len) + ((ref_addr % ref_len) + 1) % ref_len;
      else
        ref_addr = (ref_addr + 1) % SPAN;
    end
    #1 check(tag, ref_addr);
  endtask

  task automatic burst(input int unsigned a, input logic [2:0] c, input bit w,
                       input int n, input string tag);
    tick(1, 0, a, c, w, tag);
    for (int i = 0; i < n; i++) tick(0, 1, 0, 3'b000, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load = 0; step = 0; start = '0; code = 3'b000; wrap = 1'b0;
    ref_addr = 0; ref_len = 0; ref_wrap = 1;
    repeat (2) @(posedge clk);
    #1 check("R1 reset", 0);
    @(negedge clk) rst_n = 1'b1;
    // R1: default continuous mode without any load
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 3'b011, 1'b1, "R1 default");
    // R3: rollover at the top
    burst(SPAN - 2, 3'b000, 1'b1, 4, "R3 rollover");
    // R2/R4: each wrapping length
    burst('h015, 3'b010, 1'b1, 10, "R4 wrap8");
    burst('h02D, 3'b011, 1'b1, 18, "R4 wrap16");
    burst('h07B, 3'b100, 1'b1, 34, "R2 wrap32");
    burst('h3FD, 3'b010, 1'b1, 6, "R4 wrap8 top");
    // R5: no wrap crosses block edges
    burst('h01E, 3'b010, 1'b0, 4, "R5 nowrap8");
    burst('h03E, 3'b100, 1'b0, 4, "R5 nowrap32");
    // R6: reserved codes count like continuous
    burst('h007, 3'b001, 1'b1, 3, "R6 code001");
    burst('h00F, 3'b101, 1'b1, 3, "R6 code101");
    burst('h01F, 3'b110, 1'b1, 3, "R6 code110");
    burst(SPAN - 1, 3'b111, 1'b1, 2, "R6 code111");
    // R7: load wins over step in the same cycle
    burst('h100, 3'b010, 1'b1, 3, "R7 setup");
    tick(1, 1, 'h2A7, 3'b010, 1'b1, "R7 load+step");
    tick(0, 1, 0, 3'b000, 1'b0, "R7 after");
    // R8: idle cycles hold
    for (int i = 0; i < 3; i++) tick(0, 0, 'h155, 3'b100, 1'b0, "R8 idle");
    // R9: changing mode inputs mid-burst has no effect
    tick(1, 0, 'h0C6, 3'b010, 1'b1, "R9 load");
    for (int i = 0; i < 6; i++) tick(0, 1, 'h3FF, 3'b000, 1'b0, "R9 step");
    tick(0, 0, 0, 3'b000, 1'b0, "R8 idle2");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule